// File: doc/BRIEF.md
# Nibble-to-Line Symbol Encoder with Transition Serializer

This block turns a stream of 4-bit nibbles into a single-wire line signal. Each nibble, or an escape marker, is mapped to one of seventeen 5-bit line symbols. The symbol is then sent one bit per clock, highest bit first. A transition stage flips the line level for every 1 bit and leaves it unchanged for every 0 bit. The symbol set keeps any stretch of unchanged line level short, so a receiver can keep its bit timing.

Upstream logic offers nibbles on a valid/ready handshake. A separate flag marks a nibble as the escape marker. The block asks for one nibble every five clocks, in the last bit time of the symbol now on the line. If nothing is offered in that cycle, the block sends the escape symbol in its place and raises an underrun flag for that symbol. The mapping table is a parameter of the top module, so a different symbol set can be dropped in without touching the logic.

Top module: `line_sym_encoder`

## Requirements
- R1: While `rst` is high, `line_out` is 0, `underrun` is 0 and `nib_ready` is 1.
- R2: After reset, `nib_ready` is high in exactly one cycle out of every five. The cycles between two high cycles are low.
- R3: A data nibble accepted with `nib_esc` low is sent as this symbol: 0→10101, 1→01001, 2→01010, 3→01011, 4→00111, 5→01101, 6→01110, 7→01111, 8→10010, 9→11001, A→11010, B→11011, C→10111, D→11101, E→11110, F→11111. A receiver can invert the table back to the original nibble.
- R4: A nibble accepted with `nib_esc` high is sent as the escape symbol 00010, whatever value is on `nib_data`.
- R5: A nibble accepted at a clock edge (`nib_valid` and `nib_ready` both high) is sent over the next five cycles, highest symbol bit first, one bit per cycle. The first bit takes effect at that same edge.
- R6: For each symbol bit, `line_out` changes level if the bit is 1 and keeps its level if the bit is 0.
- R7: If `nib_valid` is low in a cycle where `nib_ready` is high, the next symbol is the escape symbol 00010. `underrun` is then high for all five bit cycles of that symbol.
- R8: For a symbol that comes from an accepted nibble, `underrun` is low for all five of its bit cycles.
- R9: For any input sequence, `line_out` never keeps the same level for more than five cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| nib_data | input | 4 | Nibble to encode |
| nib_esc | input | 1 | Marks the offered item as the escape marker |
| nib_valid | input | 1 | Upstream offers an item this cycle |
| nib_ready | output | 1 | Block takes an item at this clock edge |
| line_out | output | 1 | Transition-coded serial line |
| underrun | output | 1 | High while a filler escape symbol is on the line |

## Verification
Sixteen nibbles in counting order show that every table entry is distinct and sits in the right place. Escape items carrying all sixteen data values show that the data field is ignored when the flag is set. Alternating all-zero and all-one nibbles, back to back, stress the transition stage at its extremes. Runs of escapes, given on purpose and caused by missing input, push the longest quiet stretch of the line to its limit and tell real escapes apart from filler. A long pseudo-random nibble stream with random gaps then mixes every symbol pair. A bench-side transition decoder and an inverse table turn the line back into nibbles for comparison.

// File: rtl/line_sym_pkg.sv
package line_sym_pkg;

    localparam int NIB_W   = 4;
    localparam int SYM_W   = 5;
    localparam int NUM_DAT = 1 << NIB_W;
    localparam int NUM_SYM = NUM_DAT + 1;
    localparam int ESC_IDX = NUM_DAT;
    localparam int MAX_RUN = 5;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NUM_SYM-1:0][SYM_W-1:0] sym_table_t;

    typedef struct packed {
        logic esc;
        nib_t data;
    } nib_item_t;

    // Index 16 holds the escape symbol; indices 0..15 hold the data symbols.
    localparam sym_table_t DEFAULT_TABLE = {
        5'b00010,
        5'b11111, 5'b11110, 5'b11101, 5'b10111,
        5'b11011, 5'b11010, 5'b11001, 5'b10010,
        5'b01111, 5'b01110, 5'b01101, 5'b00111,
        5'b01011, 5'b01010, 5'b01001, 5'b10101
    };

    function automatic sym_t sym_lookup(input sym_table_t tbl, input nib_item_t it);
        if (it.esc)
            return tbl[ESC_IDX];
        else
            return tbl[it.data];
    endfunction

endpackage

// File: rtl/sym_map.sv
module sym_map
    import line_sym_pkg::*;
#(
    parameter sym_table_t TABLE = DEFAULT_TABLE
) (
    input  nib_item_t item,
    output sym_t      sym
);

    always_comb begin
        sym = sym_lookup(TABLE, item);
    end

endmodule

// File: rtl/slot_timer.sv
module slot_timer
    import line_sym_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic slot_end
);

    localparam int CNT_W = $clog2(SYM_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= LAST;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign slot_end = (cnt == LAST);

    // R2: a slot boundary is never followed directly by another one
    p_slot_gap_r2: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> !slot_end);

    // R2: the counter stays inside one symbol period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/nrzi_shifter.sv
module nrzi_shifter
    import line_sym_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  sym_t load_sym,
    output logic line
);

    sym_t sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            line <= 1'b0;
        end else if (load) begin
            line <= line ^ load_sym[SYM_W-1];
            sreg <= {load_sym[SYM_W-2:0], 1'b0};
        end else begin
            line <= line ^ sreg[SYM_W-1];
            sreg <= {sreg[SYM_W-2:0], 1'b0};
        end
    end

    // R6: a zero bit leaves the line level untouched
    p_zero_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !sreg[SYM_W-1]) |=> $stable(line));

    // R6: a one bit always flips the line level
    p_one_flips_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && sreg[SYM_W-1]) |=> (line != $past(line)));

endmodule

// File: rtl/line_sym_encoder.sv
module line_sym_encoder
    import line_sym_pkg::*;
#(
    parameter sym_table_t SYM_TABLE = DEFAULT_TABLE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] nib_data,
    input  logic             nib_esc,
    input  logic             nib_valid,
    output logic             nib_ready,
    output logic             line_out,
    output logic             underrun
);

    logic      slot_end;
    nib_item_t item;
    sym_t      next_sym;

    slot_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .slot_end (slot_end)
    );

    // A missing nibble becomes an escape; the data field is then don't-care.
    always_comb begin
        item.esc  = nib_esc | ~nib_valid;
        item.data = nib_data;
    end

    sym_map #(.TABLE(SYM_TABLE)) u_map (
        .item (item),
        .sym  (next_sym)
    );

    nrzi_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (slot_end),
        .load_sym (next_sym),
        .line     (line_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            underrun <= 1'b0;
        else if (slot_end)
            underrun <= ~nib_valid;
    end

    assign nib_ready = slot_end;

    // Checks on the line and the handshake
    logic [3:0] run_len;
    logic       line_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= 4'd1;
            line_d  <= 1'b0;
        end else begin
            line_d <= line_out;
            if (line_out != line_d)
                run_len <= 4'd1;
            else if (run_len != 4'hF)
                run_len <= run_len + 1'b1;
        end
    end

    // R9: the line level never sits still beyond the limit
    p_run_limit_r9: assert property (@(posedge clk) disable iff (rst)
        run_len <= 4'(MAX_RUN));

    // R7: a slot with nothing offered is flagged as filler
    p_underrun_set_r7: assert property (@(posedge clk) disable iff (rst)
        (nib_ready && !nib_valid) |=> underrun);

    // R8: an accepted nibble is never flagged as filler
    p_underrun_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (nib_ready && nib_valid) |=> !underrun);

    // R7: the flag holds steady for the whole symbol
    p_underrun_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !nib_ready |=> $stable(underrun));

endmodule

// File: tb/sim_line_sym_encoder.sv
module sim_line_sym_encoder;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] nib_data;
    logic       nib_esc;
    logic       nib_valid;
    logic       nib_ready;
    logic       line_out;
    logic       underrun;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_sym_encoder u0 (
        .clk       (clk),
        .rst       (rst),
        .nib_data  (nib_data),
        .nib_esc   (nib_esc),
        .nib_valid (nib_valid),
        .nib_ready (nib_ready),
        .line_out  (line_out),
        .underrun  (underrun)
    );

    // Bench copy of the symbol set from the requirements (R3, R4)
    function automatic logic [4:0] ref_sym(input int idx);
        case (idx)
            0: return 5'b10101;   1: return 5'b01001;
            2: return 5'b01010;   3: return 5'b01011;
            4: return 5'b00111;   5: return 5'b01101;
            6: return 5'b01110;   7: return 5'b01111;
            8: return 5'b10010;   9: return 5'b11001;
            10: return 5'b11010;  11: return 5'b11011;
            12: return 5'b10111;  13: return 5'b11101;
            14: return 5'b11110;  15: return 5'b11111;
            default: return 5'b00010;
        endcase
    endfunction

    function automatic int rev_sym(input logic [4:0] s);
        for (int i = 0; i < 17; i++)
            if (ref_sym(i) == s) return i;
        return -1;
    endfunction

    // entry: {underrun, esc_effective, data[3:0], sym[4:0]}
    logic [10:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic slot(input logic v, input logic e, input logic [3:0] d);
        logic       esc_eff;
        int         idx;
        @(negedge clk);
        while (!nib_ready) @(negedge clk);
        nib_valid = v;
        nib_esc   = e;
        nib_data  = d;
        esc_eff = e | ~v;
        idx = esc_eff ? 16 : int'(d);
        exp_q.push_back({~v, esc_eff, d, ref_sym(idx)});
        @(posedge clk);
        #1;
        nib_valid = 1'b0;
        nib_esc   = 1'b0;
        nib_data  = ~d;
    endtask

    // Monitor: transition decoder, symbol assembler, scoreboard
    bit         mon_on = 0;
    bit         armed  = 0;
    logic       prev_lvl = 1'b0;
    logic [4:0] rx_sh  = '0;
    int         nbits  = 0;
    bit         u_all  = 1;
    bit         u_any  = 0;
    int         run    = 1;
    int         max_run = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            logic b;
            b = line_out ^ prev_lvl;
            if (line_out == prev_lvl) run++; else run = 1;
            if (run > max_run) max_run = run;
            prev_lvl = line_out;
            rx_sh = {rx_sh[3:0], b};
            nbits++;
            u_all = u_all & underrun;
            u_any = u_any | underrun;
            if (nib_ready) begin
                if (armed) begin
                    check(nbits == 5, "R2 ready spacing", nbits, 5);
                    if (exp_q.size() == 0) begin
                        check(0, "R5 unexpected symbol", int'(rx_sh), 0);
                    end else begin
                        logic [10:0] e;
                        int          want_idx;
                        e = exp_q.pop_front();
                        want_idx = e[9] ? 16 : int'(e[8:5]);
                        // R3 R4 R5 R6: decoded bits, highest first
                        check(rx_sh == e[4:0], e[9] ? "R4 symbol" : "R3 symbol",
                              int'(rx_sh), int'(e[4:0]));
                        check(rev_sym(rx_sh) == want_idx, "R3 inverse lookup",
                              rev_sym(rx_sh), want_idx);
                        if (e[10])
                            check(u_all, "R7 underrun flag", int'(u_all), 1);
                        else
                            check(!u_any, "R8 underrun flag", int'(u_any), 0);
                    end
                end
                armed = 1;
                nbits = 0;
                u_all = 1;
                u_any = 0;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1;
        nib_data = '0;
        nib_esc = 1'b0;
        nib_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state held by reset
        check(line_out == 1'b0, "R1 line level", int'(line_out), 0);
        check(underrun == 1'b0, "R1 underrun", int'(underrun), 0);
        check(nib_ready == 1'b1, "R1 ready", int'(nib_ready), 1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        mon_on = 1;

        // R3: every data nibble in counting order
        for (int i = 0; i < 16; i++) slot(1'b1, 1'b0, 4'(i));
        // R4: escape carries ignored data
        for (int i = 0; i < 16; i++) slot(1'b1, 1'b1, 4'(i));
        // R6: extremes back to back
        for (int i = 0; i < 8; i++) begin
            slot(1'b1, 1'b0, 4'h0);
            slot(1'b1, 1'b0, 4'hF);
        end
        // R7 R9: filler escapes and real escapes in a row
        for (int i = 0; i < 4; i++) slot(1'b0, 1'b0, 4'h5);
        for (int i = 0; i < 4; i++) slot(1'b1, 1'b1, 4'hA);
        slot(1'b1, 1'b0, 4'h4);
        slot(1'b0, 1'b0, 4'h0);
        slot(1'b1, 1'b0, 4'h8);
        // Mixed random stream with gaps
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            slot(lfsr[7:5] != 3'b000, lfsr[11:9] == 3'b111, lfsr[3:0]);
        end
        while (exp_q.size() != 0) @(negedge clk);
        mon_on = 0;
        // R9: longest stretch of unchanged line level
        check(max_run <= 5, "R9 max run length", max_run, 5);
        finish_run();
    end

endmodule